// File: doc/BRIEF.md
# Indirect Interrupt-Redirection Register File

This block is the programmable register bank of an I/O interrupt controller serving 24 input pins. Software reaches it through only two bus locations: a select register that names an internal register, and a data window through which the named register is read or written. Behind the window sit a 4-bit controller identifier, a fixed version word and one 64-bit redirection entry per pin. Each entry is handled as two 32-bit halves.

The register bank owns the bits that software may program. Two status bits in each entry belong to the hardware, and bus writes never alter them: the remote-request flag (bit 14) and the delivery-status flag (bit 12). The interrupt dispatcher sits outside this block. It sets and clears the remote-request flag through a side port and reads any entry through a lookup port. Each accepted entry write raises a one-cycle strobe that carries the pin number, so the dispatcher can re-evaluate that pin.

Top module: `irq_redir_regfile`

## Requirements
- R1: While reset is held at a clock edge, every entry becomes 0x0000_0000_0001_0000 (only the mask bit 16 set), the identifier becomes 0 and the select register becomes 0.
- R2: A write at bus offset 0x00 stores the low 8 bits of the write data into the select register, whatever the access width. A read at offset 0x00 returns the select value zero-extended to 32 bits.
- R3: With select 0, a 32-bit window read (offset 0x10) returns the identifier in bits 27:24 and zeros elsewhere. A 32-bit window write stores write-data bits 27:24 as the new identifier.
- R4: Select 1 reads 0x0017_0020: version 0x20 in bits 7:0 and the highest pin number, 23, in bits 23:16. Select 2 reads the same value as select 0. Window writes with select 1 or 2 change neither the identifier nor any entry.
- R5: Select values from 0x10 upward address the entries. The pin number is (select − 0x10) >> 1. An even select addresses entry bits 31:0 and an odd select addresses bits 63:32. A write replaces only the addressed half.
- R6: Bits 14 and 12 of an entry keep their previous values through any bus write, apart from the clearing described in R7.
- R7: After a bus write to an entry, if the entry's bit 15 is 0 (edge trigger), bit 14 of that entry is 0.
- R8: For select values 3 to 0x0F, and for values whose pin number is 24 or more, a window read returns 0 and a window write changes no register and raises no strobe.
- R9: A window access with bus_full_word low is ignored: a write changes nothing and a read returns 0.
- R10: Each accepted entry write raises entry_changed for exactly one cycle, in the cycle after the write, with changed_pin holding the pin number. Ignored writes raise no strobe.
- R11: A side-port request writes rirr_value into bit 14 of entry rirr_pin, one cycle later. If a bus write hits the same entry in the same cycle, the bus write decides the result and the side request is dropped.
- R12: bus_rvalid and bus_rdata become valid in the cycle after a read request. bus_rvalid is low after any cycle without a read.
- R13: peek_entry shows the full current entry of pin peek_pin without delay. It is 0 for pin numbers 24 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Offset in the block: 0x00 select, 0x10 window |
| bus_full_word | input | 1 | Access is 32 bits wide |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| rirr_valid | input | 1 | Side-port request to update remote-request flag |
| rirr_pin | input | 5 | Pin addressed by the side port |
| rirr_value | input | 1 | New value of bit 14 |
| entry_changed | output | 1 | One-cycle strobe after an entry write |
| changed_pin | output | 5 | Pin whose entry was written |
| peek_pin | input | 5 | Pin selected on the lookup port |
| peek_entry | output | 64 | Current entry of peek_pin |

## Verification
A wrong internal state shows up on the window read one cycle after the request. It also shows up on peek_entry at once, because the lookup port shows every entry without delay. Errors in the hardware-owned bits are hard to see and can linger: the remote-request flag reaches the ports only through a readback or the lookup port, so the bench looks at it after each write and each side-port request. A decode fault that lets an ignored select value write an entry would otherwise stay hidden until the affected pin is read. The bench therefore compares the whole table after each sweep of such select values, and it checks the entry strobe and pin number in the cycle after every window write.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int SEL_W   = 8;
    localparam int DATA_W  = 32;
    localparam int ENT_W   = 64;
    localparam int ADDR_W  = 5;
    localparam int ID_W    = 4;
    localparam int ID_LSB  = 24;
    localparam int CNT_LSB = 16;

    localparam logic [ADDR_W-1:0] OFF_SELECT = 5'h00;
    localparam logic [ADDR_W-1:0] OFF_WINDOW = 5'h10;

    localparam logic [SEL_W-1:0] IDX_ID       = 8'h00;
    localparam logic [SEL_W-1:0] IDX_VER      = 8'h01;
    localparam logic [SEL_W-1:0] IDX_ARB      = 8'h02;
    localparam logic [SEL_W-1:0] IDX_ENT_BASE = 8'h10;

    localparam int B_MASK  = 16;
    localparam int B_TRIG  = 15;
    localparam int B_RIRR  = 14;
    localparam int B_DSTAT = 12;

    localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << B_MASK;

    typedef enum logic [2:0] {
        SK_ID, SK_VER, SK_ARB, SK_ENT, SK_NONE
    } sel_kind_e;

    typedef enum logic [2:0] {
        RS_SELECT, RS_ID, RS_VER, RS_ENT, RS_ZERO
    } rd_src_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic             upper;
        logic [SEL_W-1:0] idx;
    } sel_dec_t;

    function automatic sel_dec_t decode_select(input logic [SEL_W-1:0] sel,
                                               input int num_pins);
        sel_dec_t         d;
        logic [SEL_W-1:0] off;
        d.kind  = SK_NONE;
        d.upper = sel[0];
        d.idx   = '0;
        off     = sel - IDX_ENT_BASE;
        if (sel == IDX_ID)       d.kind = SK_ID;
        else if (sel == IDX_VER) d.kind = SK_VER;
        else if (sel == IDX_ARB) d.kind = SK_ARB;
        else if (sel >= IDX_ENT_BASE && int'(off >> 1) < num_pins) begin
            d.kind = SK_ENT;
            d.idx  = off >> 1;
        end
        return d;
    endfunction

    // Merge one written half, keep hardware-owned bits, then apply edge rule.
    function automatic logic [ENT_W-1:0] merge_half(input logic [ENT_W-1:0] old,
                                                    input logic [DATA_W-1:0] half,
                                                    input logic upper);
        logic [ENT_W-1:0] n;
        n = upper ? {half, old[DATA_W-1:0]} : {old[ENT_W-1:DATA_W], half};
        n[B_RIRR]  = old[B_RIRR];
        n[B_DSTAT] = old[B_DSTAT];
        if (!n[B_TRIG]) n[B_RIRR] = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/irq_redir_access.sv
module irq_redir_access
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_full_word,
    input  logic [SEL_W-1:0]  sel_q,
    output logic              sel_we,
    output logic              id_we,
    output logic              ent_we,
    output logic              ent_upper,
    output logic [SEL_W-1:0]  ent_idx,
    output logic              rd_en,
    output rd_src_e           rd_src
);
    sel_dec_t dec;
    logic     win_acc;

    always_comb begin
        dec       = decode_select(sel_q, NUM_PINS);
        win_acc   = bus_valid && (bus_addr == OFF_WINDOW) && bus_full_word;
        sel_we    = bus_valid && bus_write && (bus_addr == OFF_SELECT);
        id_we     = win_acc && bus_write && (dec.kind == SK_ID);
        ent_we    = win_acc && bus_write && (dec.kind == SK_ENT);
        ent_upper = dec.upper;
        ent_idx   = dec.idx;
        rd_en     = bus_valid && !bus_write;
        rd_src    = RS_ZERO;
        if (bus_addr == OFF_SELECT) begin
            rd_src = RS_SELECT;
        end else if (win_acc) begin
            unique case (dec.kind)
                SK_ID, SK_ARB: rd_src = RS_ID;
                SK_VER:        rd_src = RS_VER;
                SK_ENT:        rd_src = RS_ENT;
                default:       rd_src = RS_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/irq_redir_entries.sv
module irq_redir_entries
    import irq_redir_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = $clog2(NUM_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ent_we,
    input  logic              ent_upper,
    input  logic [SEL_W-1:0]  ent_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              side_valid,
    input  logic [PIN_W-1:0]  side_pin,
    input  logic              side_val,
    output logic [ENT_W-1:0]  ent_q [NUM_PINS],
    output logic              entry_changed,
    output logic [PIN_W-1:0]  changed_pin
);
    logic [NUM_PINS-1:0] bus_hit;
    logic [NUM_PINS-1:0] side_hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign bus_hit[i]  = ent_we && (ent_idx == SEL_W'(i));
        assign side_hit[i] = side_valid && (side_pin == PIN_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[i] <= ENT_RESET;
            end else if (bus_hit[i]) begin
                ent_q[i] <= merge_half(ent_q[i], wdata, ent_upper);
            end else if (side_hit[i]) begin
                ent_q[i][B_RIRR] <= side_val;
            end
        end

        // R1: reset leaves only the mask bit set
        p_reset_mask_r1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> ent_q[i] == ENT_RESET);
        // R6: status bits never set by a bus write
        p_ro_kept_r6: assert property (@(posedge clk) disable iff (rst)
            $past(bus_hit[i]) |-> (ent_q[i][B_DSTAT] == $past(ent_q[i][B_DSTAT]))
                               && (!ent_q[i][B_RIRR] || $past(ent_q[i][B_RIRR])));
        // R7: edge entry carries no remote request after a write
        p_edge_clear_r7: assert property (@(posedge clk) disable iff (rst)
            ($past(bus_hit[i]) && !ent_q[i][B_TRIG]) |-> !ent_q[i][B_RIRR]);
        // R11: side request lands when the bus leaves the entry alone
        p_side_write_r11: assert property (@(posedge clk) disable iff (rst)
            $past(side_hit[i] && !bus_hit[i]) |-> ent_q[i][B_RIRR] == $past(side_val));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entry_changed <= 1'b0;
            changed_pin   <= '0;
        end else begin
            entry_changed <= |bus_hit;
            for (int i = 0; i < NUM_PINS; i++) begin
                if (bus_hit[i]) changed_pin <= PIN_W'(i);
            end
        end
    end

    // R10: strobe always names a real pin
    p_changed_range_r10: assert property (@(posedge clk) disable iff (rst)
        entry_changed |-> int'(changed_pin) < NUM_PINS);
endmodule

// File: rtl/irq_redir_readmux.sv
module irq_redir_readmux
    import irq_redir_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  rd_src_e           rd_src,
    input  logic              ent_upper,
    input  logic [SEL_W-1:0]  ent_idx,
    input  logic [SEL_W-1:0]  sel_q,
    input  logic [ID_W-1:0]   id_q,
    input  logic [ENT_W-1:0]  ent_q [NUM_PINS],
    output logic [DATA_W-1:0] rd_val
);
    localparam logic [DATA_W-1:0] VER_WORD =
        (DATA_W'(NUM_PINS - 1) << CNT_LSB) | DATA_W'(VERSION);

    logic [ENT_W-1:0] ent_sel;

    always_comb begin
        ent_sel = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ent_idx == SEL_W'(i)) ent_sel = ent_q[i];
        end
        unique case (rd_src)
            RS_SELECT: rd_val = DATA_W'(sel_q);
            RS_ID:     rd_val = DATA_W'(id_q) << ID_LSB;
            RS_VER:    rd_val = VER_WORD;
            RS_ENT:    rd_val = ent_upper ? ent_sel[ENT_W-1:DATA_W] : ent_sel[DATA_W-1:0];
            default:   rd_val = '0;
        endcase
    end
endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
    import irq_redir_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h20,
    localparam int        PIN_W    = $clog2(NUM_PINS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_full_word,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              rirr_valid,
    input  logic [PIN_W-1:0]  rirr_pin,
    input  logic              rirr_value,
    output logic              entry_changed,
    output logic [PIN_W-1:0]  changed_pin,
    input  logic [PIN_W-1:0]  peek_pin,
    output logic [ENT_W-1:0]  peek_entry
);
    logic [SEL_W-1:0]  sel_q;
    logic [ID_W-1:0]   id_q;
    logic              sel_we, id_we, ent_we, ent_upper, rd_en;
    logic [SEL_W-1:0]  ent_idx;
    rd_src_e           rd_src;
    logic [DATA_W-1:0] rd_val;
    logic [ENT_W-1:0]  ent_q [NUM_PINS];

    irq_redir_access #(.NUM_PINS(NUM_PINS)) u_access (
        .bus_valid    (bus_valid),
        .bus_write    (bus_write),
        .bus_addr     (bus_addr),
        .bus_full_word(bus_full_word),
        .sel_q        (sel_q),
        .sel_we       (sel_we),
        .id_we        (id_we),
        .ent_we       (ent_we),
        .ent_upper    (ent_upper),
        .ent_idx      (ent_idx),
        .rd_en        (rd_en),
        .rd_src       (rd_src)
    );

    irq_redir_entries #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_entries (
        .clk          (clk),
        .rst          (rst),
        .ent_we       (ent_we),
        .ent_upper    (ent_upper),
        .ent_idx      (ent_idx),
        .wdata        (bus_wdata),
        .side_valid   (rirr_valid),
        .side_pin     (rirr_pin),
        .side_val     (rirr_value),
        .ent_q        (ent_q),
        .entry_changed(entry_changed),
        .changed_pin  (changed_pin)
    );

    irq_redir_readmux #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_readmux (
        .rd_src   (rd_src),
        .ent_upper(ent_upper),
        .ent_idx  (ent_idx),
        .sel_q    (sel_q),
        .id_q     (id_q),
        .ent_q    (ent_q),
        .rd_val   (rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            id_q       <= '0;
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            if (sel_we) sel_q <= bus_wdata[SEL_W-1:0];
            if (id_we)  id_q  <= bus_wdata[ID_LSB +: ID_W];
            bus_rvalid <= rd_en;
            bus_rdata  <= rd_en ? rd_val : '0;
        end
    end

    always_comb begin
        peek_entry = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (peek_pin == PIN_W'(i)) peek_entry = ent_q[i];
        end
    end

    // R12: read data arrives one cycle after the request
    p_read_latency_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid);
    p_no_spurious_rvalid_r12: assert property (@(posedge clk) disable iff (rst)
        !(bus_valid && !bus_write) |=> !bus_rvalid);
    // R10: the strobe follows only a bus write
    p_changed_after_write_r10: assert property (@(posedge clk) disable iff (rst)
        entry_changed |-> $past(bus_valid && bus_write));
    // R3: identifier moves only on a window write
    p_id_stable_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && bus_write) |-> $stable(id_q));
endmodule

// File: tb/irq_redir_regfile_test.sv
module irq_redir_regfile_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write, bus_full_word;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid;
    logic        rirr_valid, rirr_value;
    logic [4:0]  rirr_pin;
    logic        entry_changed;
    logic [4:0]  changed_pin;
    logic [4:0]  peek_pin;
    logic [63:0] peek_entry;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [63:0] m_ent [NP];
    logic [3:0]  m_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_redir_regfile uut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_full_word(bus_full_word), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .rirr_valid(rirr_valid), .rirr_pin(rirr_pin), .rirr_value(rirr_value),
        .entry_changed(entry_changed), .changed_pin(changed_pin),
        .peek_pin(peek_pin), .peek_entry(peek_entry)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Bench model of an entry write, built from R5, R6, R7.
    function automatic logic [63:0] exp_write(input logic [63:0] old,
                                              input logic [31:0] v, input bit hi);
        logic [63:0] n;
        if (hi) n = {v, old[31:0]};
        else    n = {old[63:32], v};
        n[14] = old[14];
        n[12] = old[12];
        if (n[15] == 1'b0) n[14] = 1'b0;
        return n;
    endfunction

    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, input bit full);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_full_word = full;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, input bit full, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_full_word = full;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R12", "rvalid after read", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
    endtask

    task automatic sel_wr(input logic [7:0] s);
        bus_wr(5'h00, {24'h0, s}, 1'b1);
        check("R12", "rvalid low after write", 64'(bus_rvalid), 64'd0);
    endtask

    task automatic side(input int pin, input bit v);
        rirr_valid = 1'b1; rirr_pin = 5'(pin); rirr_value = v;
        @(negedge clk);
        rirr_valid = 1'b0;
    endtask

    task automatic entry_wr(input int pin, input bit hi, input logic [31:0] v);
        sel_wr(8'(8'h10 + 2*pin + (hi ? 1 : 0)));
        bus_wr(5'h10, v, 1'b1);
        m_ent[pin] = exp_write(m_ent[pin], v, hi);
        check("R10", "strobe after entry write", 64'(entry_changed), 64'd1);
        check("R10", "changed pin", 64'(changed_pin), 64'(pin));
        @(negedge clk);
        check("R10", "strobe lasts one cycle", 64'(entry_changed), 64'd0);
    endtask

    task automatic compare_table(input string req);
        for (int p = 0; p < NP; p++) begin
            peek_pin = 5'(p);
            #1;
            check(req, $sformatf("entry %0d via lookup", p), peek_entry, m_ent[p]);
        end
    endtask

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_valid = 0; bus_write = 0; bus_addr = '0; bus_full_word = 1;
        bus_wdata = '0; rirr_valid = 0; rirr_pin = '0; rirr_value = 0; peek_pin = '0;
        for (int p = 0; p < NP; p++) m_ent[p] = 64'h1_0000;
        m_id = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        compare_table("R1");
        bus_rd(5'h00, 1'b1, rd);
        check("R1", "select after reset", 64'(rd), 64'd0);
        bus_rd(5'h10, 1'b1, rd);
        check("R1", "id after reset", 64'(rd), 64'd0);
        sel_wr(8'h10);
        bus_rd(5'h10, 1'b1, rd);
        check("R1", "entry 0 low after reset", 64'(rd), 64'h1_0000);

        // R2 select readback
        sel_wr(8'hA7);
        bus_rd(5'h00, 1'b1, rd);
        check("R2", "select readback", 64'(rd), 64'hA7);
        bus_wr(5'h00, 32'hFFFF_FF3C, 1'b0);
        bus_rd(5'h00, 1'b1, rd);
        check("R2", "select narrow write", 64'(rd), 64'h3C);

        // R3 identifier
        sel_wr(8'h00);
        bus_wr(5'h10, 32'hFFFF_FFFF, 1'b1);
        bus_rd(5'h10, 1'b1, rd);
        check("R3", "id all ones", 64'(rd), 64'h0F00_0000);
        bus_wr(5'h10, 32'hF5FF_FFFF, 1'b1);
        m_id = 4'h5;
        bus_rd(5'h10, 1'b1, rd);
        check("R3", "id five", 64'(rd), 64'h0500_0000);

        // R4 version and arbitration
        sel_wr(8'h01);
        bus_rd(5'h10, 1'b1, rd);
        check("R4", "version word", 64'(rd), 64'h0017_0020);
        bus_wr(5'h10, 32'hFFFF_FFFF, 1'b1);
        check("R4", "no strobe on version write", 64'(entry_changed), 64'd0);
        bus_rd(5'h10, 1'b1, rd);
        check("R4", "version after write", 64'(rd), 64'h0017_0020);
        sel_wr(8'h02);
        bus_rd(5'h10, 1'b1, rd);
        check("R4", "arbitration equals id", 64'(rd), 64'h0500_0000);
        bus_wr(5'h10, 32'h0A00_0000, 1'b1);
        bus_rd(5'h10, 1'b1, rd);
        check("R4", "arbitration write ignored", 64'(rd), 64'h0500_0000);
        sel_wr(8'h00);
        bus_rd(5'h10, 1'b1, rd);
        check("R4", "id after arbitration write", 64'(rd), {32'h0, 4'h0, m_id, 24'h0});
        compare_table("R4");

        // R11 side set on every pin
        for (int p = 0; p < NP; p++) begin
            side(p, 1'b1);
            m_ent[p][14] = 1'b1;
        end
        compare_table("R11");

        // R5 R6 R7 sweep over all pins, edge on even pins, level on odd
        for (int p = 0; p < NP; p++) begin
            logic [31:0] lo, hi;
            lo = 32'hC3A5_7000 ^ (32'(p) * 32'h0001_0301);
            lo[15] = p[0];
            hi = 32'h1234_0000 + 32'(p) * 32'h0100_0011;
            entry_wr(p, 1'b0, lo);
            entry_wr(p, 1'b1, hi);
            sel_wr(8'(8'h10 + 2*p));
            bus_rd(5'h10, 1'b1, rd);
            check("R5", $sformatf("pin %0d low half", p), 64'(rd), 64'(m_ent[p][31:0]));
            sel_wr(8'(8'h11 + 2*p));
            bus_rd(5'h10, 1'b1, rd);
            check("R5", $sformatf("pin %0d high half", p), 64'(rd), 64'(m_ent[p][63:32]));
            peek_pin = 5'(p);
            #1;
            check("R6", $sformatf("pin %0d status bit 12", p), 64'(peek_entry[12]), 64'd0);
            check("R7", $sformatf("pin %0d remote flag", p), 64'(peek_entry[14]),
                  (p % 2 == 1) ? 64'd1 : 64'd0);
        end

        // R11 side clear and bus priority
        side(1, 1'b0);
        m_ent[1][14] = 1'b0;
        peek_pin = 5'd1; #1;
        check("R11", "side clear pin 1", 64'(peek_entry[14]), 64'd0);
        sel_wr(8'h16);
        bus_valid = 1; bus_write = 1; bus_addr = 5'h10; bus_full_word = 1;
        bus_wdata = 32'h0000_80AB;
        rirr_valid = 1; rirr_pin = 5'd3; rirr_value = 1'b0;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; rirr_valid = 0;
        m_ent[3] = exp_write(m_ent[3], 32'h0000_80AB, 1'b0);
        peek_pin = 5'd3; #1;
        check("R11", "bus wins over side on same pin", peek_entry, m_ent[3]);

        // R8 ignored select values
        for (int s = 3; s < 16; s++) begin
            sel_wr(8'(s));
            bus_rd(5'h10, 1'b1, rd);
            check("R8", $sformatf("read select %0h", s), 64'(rd), 64'd0);
            bus_wr(5'h10, 32'hFFFF_FFFF, 1'b1);
            check("R8", "no strobe", 64'(entry_changed), 64'd0);
        end
        for (int s = 8'h40; s < 8'h51; s++) begin
            logic [7:0] sv;
            sv = (s == 8'h50) ? 8'hFF : 8'(s);
            sel_wr(sv);
            bus_rd(5'h10, 1'b1, rd);
            check("R8", $sformatf("read select %0h", sv), 64'(rd), 64'd0);
            bus_wr(5'h10, 32'hFFFF_FFFF, 1'b1);
            check("R8", "no strobe", 64'(entry_changed), 64'd0);
        end
        compare_table("R8");
        sel_wr(8'h00);
        bus_rd(5'h10, 1'b1, rd);
        check("R8", "id untouched", 64'(rd), {32'h0, 4'h0, m_id, 24'h0});

        // R9 narrow window accesses
        sel_wr(8'h1A);
        bus_wr(5'h10, 32'hFFFF_FFFF, 1'b0);
        check("R9", "no strobe on narrow write", 64'(entry_changed), 64'd0);
        peek_pin = 5'd5; #1;
        check("R9", "pin 5 unchanged", peek_entry, m_ent[5]);
        bus_rd(5'h10, 1'b0, rd);
        check("R9", "narrow read is zero", 64'(rd), 64'd0);
        sel_wr(8'h00);
        bus_wr(5'h10, 32'h0F00_0000, 1'b0);
        bus_rd(5'h10, 1'b1, rd);
        check("R9", "id unchanged by narrow write", 64'(rd), {32'h0, 4'h0, m_id, 24'h0});

        // R13 lookup beyond the last pin
        for (int p = NP; p < 32; p++) begin
            peek_pin = 5'(p); #1;
            check("R13", $sformatf("lookup pin %0d", p), peek_entry, 64'd0);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule